// File: doc/BRIEF.md
# Latched Interrupt Flag Controller

This block collects six single-cycle interrupt event pulses and keeps each one as a flag, whether or not that source is enabled. The flags sit in two status registers. The low group holds the alarm, periodic and update-ended flags; reading it clears them. The high group holds the wake-up, kickstart and RAM-clear flags; these stay set until software writes a zero to the bit.

Six enable bits, three in each of two enable registers, gate the flags onto one active-low interrupt request line. That line is a purely combinational function of the stored flags and enables. It therefore moves in the same cycle that a register write changes them.

Reading the low group follows a freeze-and-defer rule. For as long as the read strobe stays high on that register, the flags hold still. Events that arrive meanwhile go into a hidden holding register. When the strobe falls, the flags that were read are dropped and the held events are posted, so no event is lost.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After synchronous reset, every flag and every enable bit is 0, all four registers read as zero and `irq_n` is high.
- R2: A pulse on `ev_pulse` sets its flag at the next clock edge, whatever the enables hold. Bits 0, 1 and 2 (alarm, periodic, update-ended) map to bits 0..2 of the read-clear status register. Bits 3, 4 and 5 (wake-up, kickstart, RAM-clear) map to bits 0..2 of the write-zero status register.
- R3: `irq_n` is low exactly when some flag and its enable are both 1. The read-clear flags pair with the low enable register and the write-zero flags with the high enable register. Writing a 1 to the enable of a flag that is already set drives `irq_n` low right after that write's clock edge.
- R4: `reg_sel` picks the register: 0 is read-clear status, 1 is write-zero status, 2 is the low enable register and 3 is the high enable register. `rd_data` shows the selected register while `rd_stb` is high and is zero while `rd_stb` is low.
- R5: A write with `reg_sel` 2 or 3 loads `wr_data` into that enable register.
- R6: While `rd_stb` stays high with `reg_sel` 0, the read-clear flags and `rd_data` stay at their value from the start of the read.
- R7: An event on bits 0..2 that arrives during a read of register 0, or in the first cycle after the read, is posted as a flag at the first clock edge where the strobe is low.
- R8: The read-clear flags seen in a read are cleared at the first clock edge after the strobe falls, unless R7 posts them again.
- R9: Reading any register leaves the write-zero flags unchanged.
- R10: A write with `reg_sel` 1 clears each write-zero flag whose `wr_data` bit is 0 and keeps each flag whose bit is 1. An event and a clearing write in the same cycle leave the flag set.
- R11: A write with `reg_sel` 0 has no effect on the read-clear flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe for the selected register |
| wr_stb | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select (0 read-clear status, 1 write-zero status, 2 low enables, 3 high enables) |
| wr_data | input | GRP_W (3) | Write data |
| rd_data | output | GRP_W (3) | Read data, zero when not reading |
| ev_pulse | input | 2*GRP_W (6) | Interrupt event pulses, one per source |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two pairs of actions can fall in the same clock cycle. The first is a new event pulse and the end of a read of the read-clear register. The bench pulses a low-group event during a held read, and again in the first cycle after the strobe drops. It then reads the register again and expects only the new events to appear. The second is an event pulse and a clearing write to the write-zero register in the same cycle; there the flag must stay set. For every cycle, a bench model derived from the requirements gives the expected `irq_n` and read data.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
package irq_flag_pkg;

    // Flags per status register; the block has two groups of this width.
    localparam int GRP_W = 3;

    typedef enum logic [1:0] {
        SEL_STAT_RC = 2'd0,  // read-to-clear status
        SEL_STAT_WZ = 2'd1,  // write-zero-to-clear status
        SEL_EN_LO   = 2'd2,  // enables for the read-to-clear group
        SEL_EN_HI   = 2'd3   // enables for the write-zero group
    } reg_sel_e;

    typedef struct packed {
        logic rd_rc;     // read cycle on the read-to-clear status
        logic wr_wz;     // clearing write on the write-zero status
        logic wr_en_lo;  // write of low enables
        logic wr_en_hi;  // write of high enables
    } bus_dec_t;

    function automatic logic irq_pending(input logic [2*GRP_W-1:0] flags,
                                         input logic [2*GRP_W-1:0] enables);
        return |(flags & enables);
    endfunction

endpackage

// File: rtl/irq_bus_dec.sv
`timescale 1ns/1ps
module irq_bus_dec
    import irq_flag_pkg::*;
(
    input  logic     rd_stb,
    input  logic     wr_stb,
    input  logic [1:0] reg_sel,
    output bus_dec_t dec
);
    reg_sel_e sel;

    always_comb begin
        sel          = reg_sel_e'(reg_sel);
        dec.rd_rc    = rd_stb && (sel == SEL_STAT_RC);
        dec.wr_wz    = wr_stb && (sel == SEL_STAT_WZ);
        dec.wr_en_lo = wr_stb && (sel == SEL_EN_LO);
        dec.wr_en_hi = wr_stb && (sel == SEL_EN_HI);
    end
endmodule

// File: rtl/irq_rc_bank.sv
`timescale 1ns/1ps
module irq_rc_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_active,
    input  logic [W-1:0] ev,
    output logic [W-1:0] flags
);
    logic [W-1:0] shown_q;   // visible flags, frozen during a read
    logic [W-1:0] defer_q;   // events that arrived during a read
    logic         rd_q;
    logic         rd_end;

    assign rd_end = rd_q && !rd_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shown_q <= '0;
            defer_q <= '0;
            rd_q    <= 1'b0;
        end else begin
            rd_q <= rd_active;
            if (rd_active) begin
                defer_q <= defer_q | ev;
            end else if (rd_end) begin
                shown_q <= defer_q | ev;
                defer_q <= '0;
            end else begin
                shown_q <= shown_q | ev;
            end
        end
    end

    assign flags = shown_q;
endmodule

// File: rtl/irq_wz_bank.sv
`timescale 1ns/1ps
module irq_wz_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] ev,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (ev[i]) begin
                bit_q <= 1'b1;
            end else if (clr_wr && !wr_data[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags[i] = bit_q;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int GRP_W = irq_flag_pkg::GRP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic [1:0]         reg_sel,
    input  logic [GRP_W-1:0]   wr_data,
    output logic [GRP_W-1:0]   rd_data,
    input  logic [2*GRP_W-1:0] ev_pulse,
    output logic               irq_n
);
    localparam int EV_W = 2 * GRP_W;

    bus_dec_t         dec;
    logic [GRP_W-1:0] rc_flags;
    logic [GRP_W-1:0] wz_flags;
    logic [GRP_W-1:0] en_lo_q;
    logic [GRP_W-1:0] en_hi_q;
    logic [EV_W-1:0]  all_flags;
    logic [EV_W-1:0]  all_en;

    irq_bus_dec u_dec (
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .reg_sel (reg_sel),
        .dec     (dec)
    );

    irq_rc_bank #(.W(GRP_W)) u_rc (
        .clk       (clk),
        .rst       (rst),
        .rd_active (dec.rd_rc),
        .ev        (ev_pulse[GRP_W-1:0]),
        .flags     (rc_flags)
    );

    irq_wz_bank #(.W(GRP_W)) u_wz (
        .clk     (clk),
        .rst     (rst),
        .clr_wr  (dec.wr_wz),
        .wr_data (wr_data),
        .ev      (ev_pulse[EV_W-1:GRP_W]),
        .flags   (wz_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_lo_q <= '0;
            en_hi_q <= '0;
        end else begin
            if (dec.wr_en_lo) en_lo_q <= wr_data;
            if (dec.wr_en_hi) en_hi_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_stb) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_STAT_RC: rd_data = rc_flags;
                SEL_STAT_WZ: rd_data = wz_flags;
                SEL_EN_LO:   rd_data = en_lo_q;
                SEL_EN_HI:   rd_data = en_hi_q;
                default:     rd_data = '0;
            endcase
        end
    end

    assign all_flags = {wz_flags, rc_flags};
    assign all_en    = {en_hi_q, en_lo_q};
    assign irq_n     = !irq_pending(all_flags, all_en);
endmodule

// File: rtl/irq_flag_chk.sv
`timescale 1ns/1ps
module irq_flag_chk #(
    parameter int W = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_stb,
    input logic           wr_stb,
    input logic [1:0]     reg_sel,
    input logic [W-1:0]   wr_data,
    input logic [2*W-1:0] ev_pulse,
    input logic           irq_n,
    input logic [W-1:0]   rc_flags,
    input logic [W-1:0]   wz_flags,
    input logic [W-1:0]   en_lo,
    input logic [W-1:0]   en_hi
);
    assert_irq_low_R3: assert property (@(posedge clk) disable iff (rst)
        (((rc_flags & en_lo) | (wz_flags & en_hi)) != '0) |-> !irq_n);

    assert_irq_high_R3: assert property (@(posedge clk) disable iff (rst)
        (((rc_flags & en_lo) | (wz_flags & en_hi)) == '0) |-> irq_n);

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|ev_pulse[2*W-1:W]) |=>
        ((wz_flags & $past(ev_pulse[2*W-1:W])) == $past(ev_pulse[2*W-1:W])));

    assert_read_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && reg_sel == 2'd0) ##1 (rd_stb && reg_sel == 2'd0) |-> $stable(rc_flags));

    assert_wz_kept_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && reg_sel == 2'd1) |=> ((wz_flags & $past(wz_flags)) == $past(wz_flags)));

    assert_wz_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && reg_sel == 2'd1 && !wr_data[0] && !ev_pulse[W]) |=> !wz_flags[0]);
endmodule

bind irq_flag_ctrl irq_flag_chk #(.W(GRP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .reg_sel  (reg_sel),
    .wr_data  (wr_data),
    .ev_pulse (ev_pulse),
    .irq_n    (irq_n),
    .rc_flags (rc_flags),
    .wz_flags (wz_flags),
    .en_lo    (en_lo_q),
    .en_hi    (en_hi_q)
);

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
    localparam int W = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rd_stb = 1'b0;
    logic           wr_stb = 1'b0;
    logic [1:0]     reg_sel = 2'd0;
    logic [W-1:0]   wr_data = '0;
    logic [W-1:0]   rd_data;
    logic [2*W-1:0] ev_pulse = '0;
    logic           irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Requirement-level model of the block.
    logic [W-1:0] m_rc = '0, m_pend = '0, m_wz = '0, m_enl = '0, m_enh = '0;
    logic         m_rdq = 1'b0;

    always #2.5 clk = ~clk;

    irq_flag_ctrl i_irq_flag_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .reg_sel  (reg_sel),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ev_pulse (ev_pulse),
        .irq_n    (irq_n)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_irq_n();
        return !(|((m_rc & m_enl) | (m_wz & m_enh)));
    endfunction

    // One bus cycle: drive at negedge, check read data, clock, update model, check irq.
    task automatic cyc(input logic rd, input logic wr, input logic [1:0] s,
                       input logic [W-1:0] wd, input logic [2*W-1:0] ev, input string tag);
        logic         rdrc;
        logic [W-1:0] expd;
        rd_stb = rd; wr_stb = wr; reg_sel = s; wr_data = wd; ev_pulse = ev;
        #1;
        case (s)
            2'd0:    expd = m_rc;
            2'd1:    expd = m_wz;
            2'd2:    expd = m_enl;
            default: expd = m_enh;
        endcase
        if (!rd) expd = '0;
        check(rd ? tag : "R4", rd_data, expd);
        @(posedge clk);
        rdrc = rd && (s == 2'd0);
        if (rdrc) m_pend = m_pend | ev[W-1:0];
        else if (m_rdq) begin m_rc = m_pend | ev[W-1:0]; m_pend = '0; end
        else m_rc = m_rc | ev[W-1:0];
        m_rdq = rdrc;
        if (wr && s == 2'd1) m_wz = (m_wz & wd) | ev[2*W-1:W];
        else m_wz = m_wz | ev[2*W-1:W];
        if (wr && s == 2'd2) m_enl = wd;
        if (wr && s == 2'd3) m_enh = wd;
        @(negedge clk);
        check("R3", {{(W-1){1'b0}}, irq_n}, {{(W-1){1'b0}}, m_irq_n()});
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 2'd0, '0, '0, "R4");
    endtask

    task automatic clear_all();
        cyc(1'b0, 1'b1, 2'd2, '0, '0, "R5");
        cyc(1'b0, 1'b1, 2'd3, '0, '0, "R5");
        cyc(1'b0, 1'b1, 2'd1, '0, '0, "R10");
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R6");
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", {{(W-1){1'b0}}, irq_n}, {{(W-1){1'b0}}, 1'b1});
        for (int s = 0; s < 4; s++) cyc(1'b1, 1'b0, 2'(s), '0, '0, "R1");
        idle();

        // Every source, enabled and disabled: flag set and irq gating.
        for (int src = 0; src < 2*W; src++) begin
            for (int en = 0; en < 2; en++) begin
                clear_all();
                if (en == 1)
                    cyc(1'b0, 1'b1, (src < W) ? 2'd2 : 2'd3, W'(1 << (src % W)), '0, "R5");
                cyc(1'b0, 1'b0, 2'd0, '0, 6'(1 << src), "R2");
                cyc(1'b1, 1'b0, (src < W) ? 2'd0 : 2'd1, '0, '0, "R2");
                idle();
            end
        end

        // Enabling a flag that is already set drives irq at once.
        clear_all();
        cyc(1'b0, 1'b0, 2'd0, '0, 6'b100_010, "R2");
        cyc(1'b0, 1'b1, 2'd3, 3'b100, '0, "R3");
        cyc(1'b0, 1'b1, 2'd3, 3'b000, '0, "R3");
        cyc(1'b0, 1'b1, 2'd2, 3'b010, '0, "R3");
        cyc(1'b1, 1'b0, 2'd2, '0, '0, "R5");
        cyc(1'b1, 1'b0, 2'd3, '0, '0, "R5");

        // Read freeze, deferral and clear.
        clear_all();
        cyc(1'b0, 1'b1, 2'd2, 3'b111, 6'b000_001, "R5");
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R6");
        cyc(1'b1, 1'b0, 2'd0, '0, 6'b000_110, "R6");
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R6");
        idle();
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R7");
        cyc(1'b0, 1'b0, 2'd0, '0, 6'b000_100, "R7");
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R7");
        idle();
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R8");
        idle();
        // Event in the cycle right after a read's strobe falls.
        cyc(1'b0, 1'b0, 2'd0, '0, 6'b000_011, "R2");
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R8");
        cyc(1'b0, 1'b0, 2'd0, '0, 6'b000_100, "R7");
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R7");
        idle();
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R8");
        idle();

        // Writes to the read-clear status are ignored.
        cyc(1'b0, 1'b0, 2'd0, '0, 6'b000_101, "R2");
        cyc(1'b0, 1'b1, 2'd0, 3'b000, '0, "R11");
        cyc(1'b0, 1'b1, 2'd0, 3'b111, '0, "R11");
        cyc(1'b1, 1'b0, 2'd0, '0, '0, "R11");
        idle();

        // Write-zero clearing sweep over all data patterns.
        for (int d = 0; d < 8; d++) begin
            cyc(1'b0, 1'b0, 2'd0, '0, 6'b111_000, "R2");
            cyc(1'b1, 1'b0, 2'd1, '0, '0, "R9");
            cyc(1'b1, 1'b0, 2'd0, '0, '0, "R9");
            cyc(1'b1, 1'b0, 2'd1, '0, '0, "R9");
            cyc(1'b0, 1'b1, 2'd1, 3'(d), '0, "R10");
            cyc(1'b1, 1'b0, 2'd1, '0, '0, "R10");
        end
        // Event and clearing write together: event wins.
        cyc(1'b0, 1'b1, 2'd1, 3'b000, 6'b010_000, "R10");
        cyc(1'b1, 1'b0, 2'd1, '0, '0, "R10");
        cyc(1'b0, 1'b1, 2'd3, 3'b010, '0, "R3");
        cyc(1'b0, 1'b1, 2'd1, 3'b000, '0, "R10");
        cyc(1'b1, 1'b0, 2'd1, '0, '0, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule